// File: doc/BRIEF.md
# Dual-Read Single-Write Register File

This block holds the general-purpose operand registers of a small processor datapath: thirty-two registers, each eight bits wide. Two read ports return stored values with no clock delay, so both source operands of an instruction are available in the same cycle in which their 5-bit register numbers are presented. One write port stores a result on the rising clock edge.

Synchronous reset does not clear the file. It loads every register with its own register number, so a test program finds known operands in place and needs no setup instructions. Entry zero has no storage. It always reads as zero, and writes aimed at it are dropped.

Top module: `regfile_2r1w`

## Requirements
- R1: The file has NUM_REGS (default 32) registers of DATA_W (default 8) bits. Read port A and read port B each return, combinationally and independently of each other, the value held at their own address.
- R2: On a rising clock edge with `rst` high, every register n (1 to NUM_REGS-1) takes the value n. From the next cycle on, a read of address n returns n until that register is written.
- R3: A read of address 0 returns 0 on either port at all times.
- R4: On a rising clock edge with `rst` low, `wr_en` high and `wr_addr` not 0, the register at `wr_addr` takes `wr_data`. From the next cycle on, both ports return the new value at that address.
- R5: A write with `wr_addr` equal to 0 changes no register, and address 0 still reads 0 afterwards.
- R6: With `wr_en` low, no register changes, whatever `wr_addr` and `wr_data` hold.
- R7: In the cycle in which a register is being written, a read of that register returns the value it held before the edge.
- R8: When both ports address the same register, they return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; loads each register with its index |
| rd_addr_a | input | 5 | Register number for read port A |
| rd_data_a | output | 8 | Value read at `rd_addr_a` |
| rd_addr_b | input | 5 | Register number for read port B |
| rd_data_b | output | 8 | Value read at `rd_addr_b` |
| wr_addr | input | 5 | Register number for the write port |
| wr_data | input | 8 | Value to store |
| wr_en | input | 1 | Write enable |

## Verification
The reset image is swept with port A ascending and port B descending through the addresses, so a swapped or crossed read mux shows up as a mismatch. Writes to address 0, writes with the enable low, and a read of the register being written in the same cycle each separate a correct design from one that leaks a write through, or that bypasses new data to the reads. A long stretch of random addresses, data and enables runs with both ports often colliding with each other and with the write address. A second reset in mid-run confirms that the index values come back over written contents.

// File: rtl/rf_pkg.sv
package rf_pkg;
    parameter int DEF_NUM_REGS = 32;
    parameter int DEF_DATA_W   = 8;
endpackage

// File: rtl/rf_write_decode.sv
module rf_write_decode #(
    parameter int NUM_REGS = 32,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_REGS-1:1] sel
);
    // One strobe per stored register; entry zero has no strobe at all.
    always_comb begin
        for (int i = 1; i < NUM_REGS; i++) begin
            sel[i] = en && (addr == ADDR_W'(i));
        end
    end
endmodule

// File: rtl/rf_cell.sv
module rf_cell #(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= INIT;
        end else if (we) begin
            q <= d;
        end
    end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 8,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS*DATA_W-1:0] store,
    input  logic [ADDR_W-1:0]          addr,
    output logic [DATA_W-1:0]          data
);
    // Slot zero of the store vector is tied to zero by the parent.
    always_comb begin
        data = store[int'(addr)*DATA_W +: DATA_W];
    end
endmodule

// File: rtl/regfile_2r1w.sv
module regfile_2r1w #(
    parameter int NUM_REGS = rf_pkg::DEF_NUM_REGS,
    parameter int DATA_W   = rf_pkg::DEF_DATA_W,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [DATA_W-1:0] rd_data_b,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en
);
    logic [NUM_REGS-1:1]        wr_sel;
    logic [NUM_REGS*DATA_W-1:0] store;

    rf_write_decode #(.NUM_REGS(NUM_REGS)) u_dec (
        .en   (wr_en),
        .addr (wr_addr),
        .sel  (wr_sel)
    );

    // Entry zero: constant, no flops.
    assign store[DATA_W-1:0] = '0;

    for (genvar g = 1; g < NUM_REGS; g++) begin : g_reg
        rf_cell #(
            .DATA_W (DATA_W),
            .INIT   (DATA_W'(g))
        ) u_cell (
            .clk (clk),
            .rst (rst),
            .we  (wr_sel[g]),
            .d   (wr_data),
            .q   (store[g*DATA_W +: DATA_W])
        );
    end

    rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd_a (
        .store (store),
        .addr  (rd_addr_a),
        .data  (rd_data_a)
    );

    rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd_b (
        .store (store),
        .addr  (rd_addr_b),
        .data  (rd_data_b)
    );
endmodule

// File: rtl/regfile_2r1w_chk.sv
module regfile_2r1w_chk #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 8,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] rd_addr_a,
    input logic [DATA_W-1:0] rd_data_a,
    input logic [ADDR_W-1:0] rd_addr_b,
    input logic [DATA_W-1:0] rd_data_b,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_en
);
    assert_reset_index_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (rd_data_a == DATA_W'(rd_addr_a)) && (rd_data_b == DATA_W'(rd_addr_b)));

    assert_zero_read_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_a == '0) |-> (rd_data_a == '0));

    assert_write_lands_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != '0) |=>
            ((rd_addr_b == $past(wr_addr)) -> (rd_data_b == $past(wr_data))));

    assert_idle_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && $stable(rd_addr_a)) |=> (rd_addr_a != $past(rd_addr_a)) || $stable(rd_data_a));

    assert_same_addr_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_a == rd_addr_b) |-> (rd_data_a == rd_data_b));
endmodule

bind regfile_2r1w regfile_2r1w_chk #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_addr_a (rd_addr_a),
    .rd_data_a (rd_data_a),
    .rd_addr_b (rd_addr_b),
    .rd_data_b (rd_data_b),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_en     (wr_en)
);

// File: tb/test_regfile_2r1w.sv
`timescale 1ns/1ps
module test_regfile_2r1w;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] rd_addr_a = '0;
    logic [4:0] rd_addr_b = '0;
    logic [4:0] wr_addr   = '0;
    logic [7:0] wr_data   = '0;
    logic       wr_en     = 1'b0;
    logic [7:0] rd_data_a;
    logic [7:0] rd_data_b;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // Behavioural reference: plain array of ints.
    int model [32];

    always #2.5 clk = ~clk;

    regfile_2r1w i_regfile_2r1w (
        .clk       (clk),
        .rst       (rst),
        .rd_addr_a (rd_addr_a),
        .rd_data_a (rd_data_a),
        .rd_addr_b (rd_addr_b),
        .rd_data_b (rd_data_b),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_en     (wr_en)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int ref_read(input int a);
        return (a == 0) ? 0 : model[a];
    endfunction

    // One clock: drive on the falling edge, compare reads mid-low phase,
    // then update the model on the rising edge.
    task automatic cycle(input string tag, input int ra, input int rb,
                         input bit we, input int wa, input int wd);
        @(negedge clk);
        rd_addr_a = 5'(ra);
        rd_addr_b = 5'(rb);
        wr_en     = we;
        wr_addr   = 5'(wa);
        wr_data   = 8'(wd);
        #1;
        check({tag, " port A"}, int'(rd_data_a), ref_read(ra));
        check({tag, " port B"}, int'(rd_data_b), ref_read(rb));
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < 32; i++) model[i] = i;
        end else if (we && wa != 0) begin
            model[wa] = wd;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wr_en = 1'b0;
        @(posedge clk);
        for (int i = 0; i < 32; i++) model[i] = i;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = 0;
        do_reset();

        // R2 / R1: reset image, ports sweeping in opposite directions.
        for (int i = 0; i < 32; i++) cycle("R2 R1 reset image", i, 31 - i, 1'b0, 0, 0);

        // R3 / R5: write aimed at address 0 is dropped.
        cycle("R5 write to zero", 0, 0, 1'b1, 0, 8'hAA);
        cycle("R3 zero after write", 0, 1, 1'b0, 0, 0);

        // R6: enable low, data and address present, no effect.
        cycle("R6 disabled write", 5, 6, 1'b0, 5, 8'hFF);
        cycle("R6 value held", 5, 5, 1'b0, 0, 0);

        // R7 then R4: same-cycle read gives old value, next cycle new.
        cycle("R7 read during write", 9, 9, 1'b1, 9, 8'h5C);
        cycle("R4 read after write", 9, 8, 1'b0, 0, 0);
        cycle("R4 write top entry", 31, 30, 1'b1, 31, 8'hC3);
        cycle("R4 top entry readback", 30, 31, 1'b0, 0, 0);

        // R8: both ports same register.
        cycle("R8 shared address", 9, 9, 1'b0, 0, 0);

        // Mixed random traffic, compared every clock.
        for (int n = 0; n < 400; n++) begin
            int ra = $urandom_range(0, 31);
            int rb = ($urandom_range(0, 3) == 0) ? ra : $urandom_range(0, 31);
            int wa = ($urandom_range(0, 2) == 0) ? ra : $urandom_range(0, 31);
            cycle("R1 R4 R7 random", ra, rb, 1'($urandom_range(0, 1)), wa,
                  $urandom_range(0, 255));
        end

        // R2: reset again brings back the index values.
        do_reset();
        for (int i = 0; i < 32; i++) cycle("R2 second reset", 31 - i, i, 1'b0, 0, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule